// File: doc/BRIEF.md
# Programmable CRT Raster Timing Generator

This block produces the scan timing for a raster display. A horizontal pixel counter and a vertical line counter sweep the frame. The block compares them against software-loaded geometry to produce a data-enable window, a blanking flag, a horizontal sync, a vertical sync and a second vertical sync for a flat-panel path. The panel sync has its own start and end values, so software can place it one line ahead of the tube sync. The current pixel column and line row are also output.

Software loads the geometry through a write-only port of eight 32-bit words. Each timing word holds two 11-bit values, each written as the real count minus one. Geometry writes go into a shadow copy. The live copy takes them only when a new frame starts, so no frame is ever drawn with mixed geometry. Sync polarity and the run enable act at once.

A three-state sequencer drives the counters:
- `ST_OFF`: the block is idle, the counters are held at zero and every output is at its inactive level.
- `ST_PRIME`: a single cycle in which the live geometry is copied from the shadow.
- `ST_RUN`: the counters sweep the frame.

The transitions are:
- OFF to PRIME on "enable set".
- PRIME to RUN on "enable still set".
- RUN to RUN on "frame wrap", which also reloads the live geometry.
- PRIME to OFF and RUN to OFF on "enable cleared".

Top module: `crt_timing_gen`

## Requirements
- R1: Register layout, by word address:
  - The timing words are: 0 horizontal active/total, 1 horizontal blank start/end, 2 horizontal sync start/end, 3 vertical active/total, 4 vertical blank start/end, 5 vertical sync start/end, 6 panel vertical sync start/end.
  - In each timing word, bits 10:0 hold the first value minus one and bits 26:16 hold the second value minus one.
  - Word 7 is control: bit 0 makes hsync active-low, bit 1 makes both vertical syncs active-low, and bit 2 is the run enable. A cleared polarity bit means active-high.
- R2: While running, `pixel_x` counts from 0 up to the stored horizontal total and then returns to 0. At that return `line_y` advances by one. `line_y` returns to 0 after the stored vertical total. The first running cycle shows pixel 0 on line 0.
- R3: `de` is high exactly when `pixel_x` is no greater than the stored horizontal active value and `line_y` is no greater than the stored vertical active value.
- R4: `blank` is high when `pixel_x` is above the stored horizontal blank start and no greater than the stored horizontal blank end, or when `line_y` meets the same test against the vertical blank pair.
- R5: The hsync pulse is active while `pixel_x` is at or above the stored sync start and below the stored sync end. Its output level is the active state XORed with control bit 0.
- R6: The vsync pulse is active while `line_y` is at or above the stored vertical sync start and below its stored end. Its output level is XORed with control bit 1.
- R7: `panel_vsync` follows the rule of R6 using word 6 and the same polarity bit. Loading word 6 with both values one below word 5 makes it lead vsync by one line.
- R8: A geometry write becomes visible only from the first pixel of the next frame. A write captured on the clock edge that wraps the frame is seen only one frame later.
- R9: A write to the polarity bits changes the sync output levels from the next cycle on, in the middle of a frame.
- R10: When enable is cleared, in the next cycle `de`=0, `blank`=1, the syncs are at their inactive levels, and `pixel_x`=`line_y`=0. When enable is set while idle, there are two idle-looking cycles, then the scan starts at pixel 0, line 0 with the shadow geometry.
- R11: Two reference modes give correct timing:
  - 640 active, sync 664 to 704, total 832 pixels, with active-low syncs.
  - 1280 active, sync 1328 to 1440, total 1688 pixels, with active-high syncs.
- R12: After reset all registers are zero and the block is idle, with `de`=0, `blank`=1, `hsync`=`vsync`=`panel_vsync`=0 and both coordinates zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity per control bit 0 |
| vsync | output | 1 | Vertical sync, polarity per control bit 1 |
| panel_vsync | output | 1 | Separately timed vertical sync for a panel |
| de | output | 1 | Active video window |
| blank | output | 1 | Blanking interval |
| pixel_x | output | 11 | Current pixel column |
| line_y | output | 11 | Current line row |

## Verification
The hardest case to reach from the ports is a geometry write that lands exactly on the frame-wrap clock edge. In that case the shadow copy updates on the same edge that the live copy reloads, so the new value must wait a full extra frame. The bench keeps its own cycle-accurate frame position and fires a write on the last pixel of the last line. Its model applies the reload before the shadow update, so the expected delay follows from arithmetic alone. A second write in the middle of a frame, followed by a sweep across the next frames, confirms that earlier geometry writes take effect exactly at the frame boundary.

// File: rtl/crt_pkg.sv
package crt_pkg;
    localparam int unsigned CW     = 11;
    localparam int unsigned DW     = 32;
    localparam int unsigned AW     = 3;
    localparam int unsigned HI_LSB = 16;
    localparam int unsigned NGEO   = 7;

    localparam logic [AW-1:0] A_HTOT  = 3'd0;
    localparam logic [AW-1:0] A_HBLK  = 3'd1;
    localparam logic [AW-1:0] A_HSYN  = 3'd2;
    localparam logic [AW-1:0] A_VTOT  = 3'd3;
    localparam logic [AW-1:0] A_VBLK  = 3'd4;
    localparam logic [AW-1:0] A_VSYN  = 3'd5;
    localparam logic [AW-1:0] A_PSYN  = 3'd6;
    localparam logic [AW-1:0] A_CTRL  = 3'd7;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2
    } scan_state_e;

    typedef struct packed {
        logic [CW-1:0] hi;
        logic [CW-1:0] lo;
    } pair_t;

    typedef struct packed {
        pair_t h_tot;
        pair_t h_blk;
        pair_t h_syn;
        pair_t v_tot;
        pair_t v_blk;
        pair_t v_syn;
        pair_t p_syn;
    } geom_t;
endpackage

// File: rtl/crt_regfile.sv
module crt_regfile
    import crt_pkg::*;
#(
    parameter int unsigned AW_P = AW,
    parameter int unsigned DW_P = DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW_P-1:0] wr_addr,
    input  logic [DW_P-1:0] wr_data,
    input  logic            load_i,
    output geom_t           geom_o,
    output logic            en_o,
    output logic            hneg_o,
    output logic            vneg_o
);
    localparam int unsigned HI_MSB = HI_LSB + CW - 1;

    pair_t shadow [NGEO];
    pair_t live   [NGEO];

    for (genvar g = 0; g < NGEO; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow[g] <= '0;
            end else if (wr_en && (wr_addr == AW_P'(g))) begin
                shadow[g].lo <= wr_data[CW-1:0];
                shadow[g].hi <= wr_data[HI_MSB:HI_LSB];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live[g] <= '0;
            end else if (load_i) begin
                live[g] <= shadow[g];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o   <= 1'b0;
            hneg_o <= 1'b0;
            vneg_o <= 1'b0;
        end else if (wr_en && (wr_addr == A_CTRL)) begin
            hneg_o <= wr_data[0];
            vneg_o <= wr_data[1];
            en_o   <= wr_data[2];
        end
    end

    assign geom_o.h_tot = live[A_HTOT];
    assign geom_o.h_blk = live[A_HBLK];
    assign geom_o.h_syn = live[A_HSYN];
    assign geom_o.v_tot = live[A_VTOT];
    assign geom_o.v_blk = live[A_VBLK];
    assign geom_o.v_syn = live[A_VSYN];
    assign geom_o.p_syn = live[A_PSYN];
endmodule

// File: rtl/crt_scan_fsm.sv
module crt_scan_fsm
    import crt_pkg::*;
#(
    parameter int unsigned CW_P = CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [CW_P-1:0] h_last_i,
    input  logic [CW_P-1:0] v_last_i,
    output scan_state_e     state_o,
    output logic [CW_P-1:0] h_o,
    output logic [CW_P-1:0] v_o,
    output logic            load_o
);
    scan_state_e     state_q, state_d;
    logic [CW_P-1:0] h_q, v_q;
    logic            h_wrap, frame_end, advance;

    assign h_wrap    = (h_q >= h_last_i);
    assign frame_end = h_wrap && (v_q >= v_last_i);
    assign advance   = (state_q == ST_RUN) && en_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   state_d = en_i ? ST_PRIME : ST_OFF;
            ST_PRIME: state_d = en_i ? ST_RUN   : ST_OFF;
            ST_RUN:   state_d = en_i ? ST_RUN   : ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
            v_q <= '0;
        end else if (!advance) begin
            h_q <= '0;
            v_q <= '0;
        end else if (h_wrap) begin
            h_q <= '0;
            v_q <= (v_q >= v_last_i) ? '0 : v_q + 1'b1;
        end else begin
            h_q <= h_q + 1'b1;
        end
    end

    always_comb begin
        load_o = 1'b0;
        unique case (state_q)
            ST_PRIME: load_o = 1'b1;
            ST_RUN:   load_o = frame_end;
            default:  load_o = 1'b0;
        endcase
    end

    assign state_o = state_q;
    assign h_o     = h_q;
    assign v_o     = v_q;

    assert_col_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (h_q <= h_last_i));

    assert_line_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && en_i && !h_wrap) |=> $stable(v_q));

    assert_start_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIME && en_i) |=> (state_q == ST_RUN && h_q == '0 && v_q == '0));

    assert_off_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> (state_q == ST_OFF));
endmodule

// File: rtl/crt_window.sv
module crt_window #(
    parameter int unsigned CW_P = 11
) (
    input  logic [CW_P-1:0] pos_i,
    input  logic [CW_P-1:0] start_i,
    input  logic [CW_P-1:0] stop_i,
    output logic            hit_o
);
    assign hit_o = (pos_i >= start_i) && (pos_i < stop_i);
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
    import crt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          hsync,
    output logic          vsync,
    output logic          panel_vsync,
    output logic          de,
    output logic          blank,
    output logic [CW-1:0] pixel_x,
    output logic [CW-1:0] line_y
);
    localparam int unsigned NWIN = 3;

    geom_t         geom;
    logic          en, hneg, vneg, load;
    scan_state_e   state;
    logic [CW-1:0] h, v;
    logic          running, de_raw, hblk, vblk;

    logic [CW-1:0] win_pos   [NWIN];
    logic [CW-1:0] win_start [NWIN];
    logic [CW-1:0] win_stop  [NWIN];
    logic [NWIN-1:0] win_hit;

    crt_regfile #(.AW_P(AW), .DW_P(DW)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load_i  (load),
        .geom_o  (geom),
        .en_o    (en),
        .hneg_o  (hneg),
        .vneg_o  (vneg)
    );

    crt_scan_fsm #(.CW_P(CW)) i_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .h_last_i (geom.h_tot.hi),
        .v_last_i (geom.v_tot.hi),
        .state_o  (state),
        .h_o      (h),
        .v_o      (v),
        .load_o   (load)
    );

    assign win_pos[0]   = h;
    assign win_start[0] = geom.h_syn.lo;
    assign win_stop[0]  = geom.h_syn.hi;
    assign win_pos[1]   = v;
    assign win_start[1] = geom.v_syn.lo;
    assign win_stop[1]  = geom.v_syn.hi;
    assign win_pos[2]   = v;
    assign win_start[2] = geom.p_syn.lo;
    assign win_stop[2]  = geom.p_syn.hi;

    for (genvar k = 0; k < NWIN; k++) begin : g_sync
        crt_window #(.CW_P(CW)) i_win (
            .pos_i   (win_pos[k]),
            .start_i (win_start[k]),
            .stop_i  (win_stop[k]),
            .hit_o   (win_hit[k])
        );
    end

    assign running = (state == ST_RUN) && en;
    assign de_raw  = (h <= geom.h_tot.lo) && (v <= geom.v_tot.lo);
    assign hblk    = (h > geom.h_blk.lo) && (h <= geom.h_blk.hi);
    assign vblk    = (v > geom.v_blk.lo) && (v <= geom.v_blk.hi);

    always_comb begin
        if (running) begin
            hsync       = win_hit[0] ^ hneg;
            vsync       = win_hit[1] ^ vneg;
            panel_vsync = win_hit[2] ^ vneg;
            de          = de_raw;
            blank       = hblk || vblk;
            pixel_x     = h;
            line_y      = v;
        end else begin
            hsync       = hneg;
            vsync       = vneg;
            panel_vsync = vneg;
            de          = 1'b0;
            blank       = 1'b1;
            pixel_x     = '0;
            line_y      = '0;
        end
    end

    assert_frame_geom_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !(h == geom.h_tot.hi && v == geom.v_tot.hi)) |=> $stable(geom));

    assert_idle_levels_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (!de && blank && pixel_x == '0 && line_y == '0));
endmodule

// File: tb/test_crt_timing_gen.sv
`timescale 1ns/1ps
module test_crt_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, panel_vsync, de, blank;
    logic [10:0] pixel_x, line_y;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] m_sh  [7];
    logic [31:0] m_act [7];
    logic [2:0]  m_ctl;
    int          mh, mv;
    bit          mrun;

    always #2 clk = ~clk;

    crt_timing_gen i_crt_timing_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .panel_vsync(panel_vsync), .de(de), .blank(blank),
        .pixel_x(pixel_x), .line_y(line_y)
    );

    function automatic logic [31:0] pk(int lo, int hi);
        return (32'(hi) << 16) | 32'(lo);
    endfunction

    function automatic int lo(int a);
        return int'(m_act[a][10:0]);
    endfunction

    function automatic int hi(int a);
        return int'(m_act[a][26:16]);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (x=%0d y=%0d)", req, act, exp, mh, mv);
        end
    endtask

    task automatic check_now(string tag);
        int e_hs, e_vs, e_ps, e_de, e_bl, e_x, e_y;
        if (mrun) begin
            e_x  = mh;
            e_y  = mv;
            e_de = (mh <= lo(0) && mv <= lo(3)) ? 1 : 0;
            e_bl = ((mh > lo(1) && mh <= hi(1)) || (mv > lo(4) && mv <= hi(4))) ? 1 : 0;
            e_hs = ((mh >= lo(2) && mh < hi(2)) ? 1 : 0) ^ int'(m_ctl[0]);
            e_vs = ((mv >= lo(5) && mv < hi(5)) ? 1 : 0) ^ int'(m_ctl[1]);
            e_ps = ((mv >= lo(6) && mv < hi(6)) ? 1 : 0) ^ int'(m_ctl[1]);
        end else begin
            e_x = 0; e_y = 0; e_de = 0; e_bl = 1;
            e_hs = int'(m_ctl[0]); e_vs = int'(m_ctl[1]); e_ps = int'(m_ctl[1]);
        end
        chk({tag, " R2 pixel_x"}, int'(pixel_x), e_x);
        chk({tag, " R2 line_y"}, int'(line_y), e_y);
        chk({tag, " R3 de"}, int'(de), e_de);
        chk({tag, " R4 blank"}, int'(blank), e_bl);
        chk({tag, " R5 R9 hsync"}, int'(hsync), e_hs);
        chk({tag, " R6 R9 vsync"}, int'(vsync), e_vs);
        chk({tag, " R7 panel_vsync"}, int'(panel_vsync), e_ps);
    endtask

    // Write while the scan is not being modelled cycle by cycle
    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 7) begin
            m_ctl = d[2:0];
            if (!d[2]) mrun = 1'b0;
        end else begin
            m_sh[a] = d;
        end
    endtask

    task automatic advance(bit fire, int a, logic [31:0] d);
        bit hw, fe;
        hw = (mh == hi(0));
        fe = hw && (mv == hi(3));
        if (fe) for (int k = 0; k < 7; k++) m_act[k] = m_sh[k];
        if (fire) begin
            if (a == 7) m_ctl = d[2:0];
            else        m_sh[a] = d;
        end
        if (hw) begin
            mh = 0;
            mv = (mv == int'(m_act[3][26:16]) || fe) ? 0 : mv + 1;
        end else begin
            mh = mh + 1;
        end
    endtask

    task automatic run(int n, int inj, int a, logic [31:0] d, string tag);
        for (int i = 0; i < n; i++) begin
            bit fire;
            fire = (i == inj);
            check_now(tag);
            if (fire) begin
                wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
            end
            @(negedge clk);
            wr_en = 1'b0;
            advance(fire, a, d);
        end
    endtask

    task automatic start(logic [2:0] pol, string tag);
        wr(7, {29'd0, 1'b1, pol[1:0]});
        check_now({tag, " R10 enable+0"});
        @(negedge clk);
        check_now({tag, " R10 prime"});
        @(negedge clk);
        for (int k = 0; k < 7; k++) m_act[k] = m_sh[k];
        mh = 0; mv = 0; mrun = 1'b1;
    endtask

    task automatic load_set(logic [31:0] s [7]);
        for (int k = 0; k < 7; k++) wr(k, s[k]);
    endtask

    logic [31:0] geo_a [7];
    logic [31:0] geo_b [7];
    logic [31:0] geo_v [7];
    logic [31:0] geo_r [7];

    initial begin
        #(4 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 7; k++) begin m_sh[k] = '0; m_act[k] = '0; end
        m_ctl = '0; mh = 0; mv = 0; mrun = 1'b0;

        geo_a = '{pk(9,15), pk(9,15), pk(11,13), pk(5,9), pk(5,9), pk(6,8), pk(5,7)};
        geo_b = '{pk(5,8), pk(3,7), pk(6,7), pk(3,6), pk(2,5), pk(4,5), pk(3,4)};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check_now("R12 reset");

        // R1 layout, first frames of geometry A with a mid-frame polarity change (R9)
        load_set(geo_a);
        start(3'b000, "A");
        run(40, -1, 0, '0, "A");
        run(200, 10, 7, 32'h7, "A R9");

        // R8: rewrite all geometry mid-frame; old geometry holds until the wrap
        run(5, -1, 0, '0, "A");
        for (int k = 0; k < 7; k++) run(1, 0, k, geo_b[k], "R8 mid");
        run(400, -1, 0, '0, "R8 B");

        // R8 corner: a write captured on the frame-wrap edge waits one more frame
        while (!(mh == hi(0) && mv == hi(3))) run(1, -1, 0, '0, "R8 seek");
        run(1, 0, 0, pk(6, 10), "R8 edge");
        run(300, -1, 0, '0, "R8 late");

        // R10 disable: outputs go idle at once
        wr(7, 32'h3);
        check_now("R10 disable");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_now("R10 hold");
        end

        // Sweep of small geometries
        for (int ht = 4; ht <= 8; ht++) begin
            for (int vt = 3; vt <= 5; vt++) begin
                geo_v = '{pk(ht-3, ht-1), pk(ht-3, ht-1), pk(ht-2, ht-1),
                          pk(vt-2, vt-1), pk(vt-2, vt-1), pk(vt-2, vt-1), pk(vt-3, vt-2)};
                wr(7, 32'h0);
                load_set(geo_v);
                start(3'(ht & 3), "sweep");
                run(ht * vt * 2 + 3, -1, 0, '0, "sweep");
            end
        end
        wr(7, 32'h0);

        // R11 first reference mode, active-low syncs
        geo_r = '{pk(639,831), pk(639,831), pk(663,703), pk(479,519), pk(479,519),
                  pk(488,490), pk(487,489)};
        load_set(geo_r);
        start(3'b011, "R11 640");
        run(832 * 3, -1, 0, '0, "R11 640");
        wr(7, 32'h3);

        // R11 second reference mode, active-high syncs
        geo_r = '{pk(1279,1687), pk(1279,1687), pk(1327,1439), pk(1023,1065), pk(1023,1065),
                  pk(1024,1027), pk(1023,1026)};
        load_set(geo_r);
        start(3'b000, "R11 1280");
        run(1688 * 2 + 10, -1, 0, '0, "R11 1280");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule